// File: doc/BRIEF.md
# Display Command List Sequencer

This block keeps a short list of display-bus entries that a host writes ahead of time. Each entry is either a command or a data value. On a start request the block replays the list, one entry per accepted transfer, to a parallel display bus engine downstream. The host sets up the list and a control word through a simple write port. It starts the replay by writing the run register, and it watches a busy output and a done flag to learn when the list has drained. The done flag can also raise an interrupt. Each entry is flagged inline as command or data, so command bytes and their parameters can be mixed freely in one list.

Host write map, by byte address:
- Control word at 0x00: bit 15 enables the list, and bits [12:8] hold the entry count.
- Run register at 0x04: bit 15 is the run bit.
- Interrupt enable at 0x08: bit 0.
- Status at 0x0C: bit 0 is done, cleared by writing a 1.

List slot n sits at byte address 0x80 + 4·n. The slot region starts at 4·2^CNT_W in general.

Top module: `cmdlist_top`

## Requirements
- R1: In a list word, bit 23 selects the kind of entry (1 = command, 0 = data), and bits [15:0] are the value put on `outData`. All other bits of the word have no effect on the output.
- R2: Entries leave in slot order 0, 1, 2, … with one entry per cycle in which `outValid` and `outReady` are both high.
- R3: Exactly as many entries are sent as the count in control bits [12:8]. A count of zero completes at once: done is set and nothing is emitted.
- R4: When control bit 15 is clear, a start emits nothing and sets done at once.
- R5: A dispatch starts only when a run-register write carries bit 15 = 1 while the stored run bit is 0. Writing 0x8000 again while the run bit is already 1 starts nothing.
- R6: A run-register write with bit 15 = 0 stops a dispatch in progress. `outValid` and `busy` fall on the next cycle, and done is not set.
- R7: `busy` rises in the cycle after the starting write. It falls after the handshake of the last entry.
- R8: While `outReady` is low, `outValid`, `outIsCmd` and `outData` hold steady.
- R9: Done is set at the handshake of the last entry. Writing status bit 0 = 1 clears it, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly when done is set and interrupt-enable bit 0 is 1.
- R11: The count is captured at start. Rewriting the control word during a dispatch does not change how many entries are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | CNT_W+3 | Host byte address |
| hostWdata | input | 32 | Host write data |
| busy | output | 1 | Dispatch in progress |
| doneFlag | output | 1 | Completion status bit |
| irq | output | 1 | Completion interrupt |
| outValid | output | 1 | Entry offered downstream |
| outReady | input | 1 | Downstream accepts entry |
| outIsCmd | output | 1 | Offered entry is a command |
| outData | output | 16 | Offered entry value |

## Verification
The bench builds the block with its default CNT_W of 5. This gives a 32-slot list and an 8-bit address. With that width, a full 31-entry dispatch is short enough to replay and compare slot by slot. The same run also covers the zero-count case and the rollover of the count field into the latch. Smaller widths would hide the upper count bits, and larger ones would only make the replay longer.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;

  typedef struct packed {
    logic load;
    logic advance;
    logic finish;
    logic abort;
  } dispStrb_t;

  localparam int ENTRY_W  = 17;
  localparam int FLAG_BIT = 23;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_RUN  = 2'd1;
  localparam logic [1:0] REG_IEN  = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

endpackage

// File: rtl/cmdlist_datapath.sv
module cmdlist_datapath
  import cmdlist_pkg::*;
#(
  parameter int CNT_W = 5,
  localparam int ADDR_W = CNT_W + 3,
  localparam int DEPTH = 1 << CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  input  dispStrb_t         strb,
  output logic              startReq,
  output logic              stopReq,
  output logic              listEmpty,
  output logic              ptrLast,
  output logic              doneFlag,
  output logic              irq,
  output logic              outIsCmd,
  output logic [15:0]       outData
);

  logic [ENTRY_W-1:0] listMem [DEPTH];
  logic [CNT_W-1:0]   slotSel;
  logic               listWr, regWr;
  logic [1:0]         regIdx;
  logic               cmdEn, runBit, intEn;
  logic [CNT_W-1:0]   cntCfg, cntLatch, ptr;

  assign listWr  = hostWe && hostAddr[ADDR_W-1];
  assign regWr   = hostWe && !hostAddr[ADDR_W-1];
  assign slotSel = hostAddr[ADDR_W-2:2];
  assign regIdx  = hostAddr[3:2];

  always_ff @(posedge clk) begin
    if (listWr) listMem[slotSel] <= {hostWdata[FLAG_BIT], hostWdata[15:0]};
  end

  assign startReq  = regWr && regIdx == REG_RUN && hostWdata[15] && !runBit;
  assign stopReq   = regWr && regIdx == REG_RUN && !hostWdata[15];
  assign listEmpty = !cmdEn || cntCfg == '0;
  assign ptrLast   = ptr == cntLatch - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdEn  <= 1'b0;
      cntCfg <= '0;
      runBit <= 1'b0;
      intEn  <= 1'b0;
    end else if (regWr) begin
      case (regIdx)
        REG_CTRL: begin
          cmdEn  <= hostWdata[15];
          cntCfg <= hostWdata[8 +: CNT_W];
        end
        REG_RUN: runBit <= hostWdata[15];
        REG_IEN: intEn  <= hostWdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      cntLatch <= '0;
    end else if (strb.load) begin
      ptr      <= '0;
      cntLatch <= cntCfg;
    end else if (strb.advance) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneFlag <= 1'b0;
    else if (strb.finish) doneFlag <= 1'b1;
    else if (regWr && regIdx == REG_STAT && hostWdata[0]) doneFlag <= 1'b0;
  end

  assign irq      = doneFlag && intEn;
  assign outIsCmd = listMem[ptr][ENTRY_W-1];
  assign outData  = listMem[ptr][15:0];

  AST_LOAD_RESETS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> ptr == '0); // R2
  AST_ADVANCE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> ptr < cntLatch); // R3
  AST_FINISH_SETS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> doneFlag); // R9

endmodule

// File: rtl/cmdlist_ctrl.sv
module cmdlist_ctrl
  import cmdlist_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      stopReq,
  input  logic      listEmpty,
  input  logic      ptrLast,
  input  logic      outReady,
  output dispStrb_t strb,
  output logic      sending
);

  typedef enum logic {ST_IDLE, ST_SEND} state_t;
  state_t state, stateNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (listEmpty) strb.finish = 1'b1;
          else begin
            strb.load = 1'b1;
            stateNxt  = ST_SEND;
          end
        end
      end
      ST_SEND: begin
        if (stopReq) begin
          strb.abort = 1'b1;
          stateNxt   = ST_IDLE;
        end else if (outReady) begin
          strb.advance = 1'b1;
          if (ptrLast) begin
            strb.finish = 1'b1;
            stateNxt    = ST_IDLE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign sending = state == ST_SEND;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (sending && !outReady && !stopReq) |=> sending); // R8
  AST_FINISH_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !sending); // R7
  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    (sending && stopReq) |=> !sending); // R6

endmodule

// File: rtl/cmdlist_top.sv
module cmdlist_top
  import cmdlist_pkg::*;
#(
  parameter int CNT_W = 5,
  localparam int ADDR_W = CNT_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic              busy,
  output logic              doneFlag,
  output logic              irq,
  output logic              outValid,
  input  logic              outReady,
  output logic              outIsCmd,
  output logic [15:0]       outData
);

  dispStrb_t strb;
  logic startReq, stopReq, listEmpty, ptrLast, sending;

  cmdlist_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .strb(strb), .startReq(startReq),
    .stopReq(stopReq), .listEmpty(listEmpty), .ptrLast(ptrLast),
    .doneFlag(doneFlag), .irq(irq), .outIsCmd(outIsCmd), .outData(outData)
  );

  cmdlist_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .listEmpty(listEmpty), .ptrLast(ptrLast), .outReady(outReady),
    .strb(strb), .sending(sending)
  );

  assign busy     = sending;
  assign outValid = sending;

endmodule

// File: tb/sim_cmdlist_top.sv
module sim_cmdlist_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWe = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic busy, doneFlag, irq, outValid, outIsCmd, outReady;
  logic [15:0] outData;
  logic readyVal = 1'b1;
  logic stallPattern = 1'b0;
  logic tog = 1'b0;

  int checks = 0;
  int errors = 0;
  int capN = 0;
  logic capCmd [64];
  logic [15:0] capData [64];
  logic [31:0] slotWord [32];
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign outReady = stallPattern ? tog : readyVal;
  always @(negedge clk) tog <= ~tog;

  cmdlist_top u0 (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .busy(busy), .doneFlag(doneFlag), .irq(irq),
    .outValid(outValid), .outReady(outReady), .outIsCmd(outIsCmd),
    .outData(outData)
  );

  always @(negedge clk) begin
    #(CLK_PERIOD / 4);
    if (rstN && outValid && outReady && capN < 64) begin
      capCmd[capN]  = outIsCmd;
      capData[capN] = outData;
      capN++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = addr; hostWdata = data;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic putSlot(input int n, input logic [31:0] w);
    slotWord[n] = w;
    wr(8'h80 + 8'(4 * n), w);
  endtask

  task automatic startRun();
    wr(8'h0C, 32'h1);
    wr(8'h04, 32'h0);
    capN = 0;
    wr(8'h04, 32'h8000);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmpList(input string req, input int n);
    chk(req, capN, n);
    for (int i = 0; i < n && i < capN; i++) begin
      chk(req, {15'd0, capCmd[i], capData[i]},
          {15'd0, slotWord[i][23], slotWord[i][15:0]});
    end
  endtask

  task automatic tReset();
    chk("R7 reset busy", busy, 0);
    chk("R8 reset valid", outValid, 0);
    chk("R9 reset done", doneFlag, 0);
    chk("R10 reset irq", irq, 0);
  endtask

  task automatic tBasic();
    putSlot(0, 32'h0080_002A);
    putSlot(1, 32'hFF7F_1234);
    putSlot(2, 32'h0000_00EF);
    putSlot(3, 32'h0180_BEEF);
    wr(8'h00, 32'h8000 | (4 << 8));
    startRun();
    chk("R7 busy after start", busy, 1);
    waitIdle();
    cmpList("R1 R2 R3 basic", 4);
    chk("R9 done after list", doneFlag, 1);
    chk("R7 busy after list", busy, 0);
  endtask

  task automatic tStall();
    readyVal = 1'b0;
    wr(8'h00, 32'h8000 | (2 << 8));
    startRun();
    for (int i = 0; i < 3; i++) begin
      chk("R8 valid held", outValid, 1);
      chk("R8 data held", outData, 16'h002A);
      chk("R8 flag held", outIsCmd, 1);
      @(negedge clk);
    end
    stallPattern = 1'b1;
    waitIdle();
    stallPattern = 1'b0;
    readyVal = 1'b1;
    cmpList("R2 R8 stalled order", 2);
  endtask

  task automatic tZero();
    wr(8'h00, 32'h8000);
    startRun();
    chk("R3 zero count busy", busy, 0);
    chk("R3 zero count done", doneFlag, 1);
    repeat (3) @(negedge clk);
    chk("R3 zero count emits", capN, 0);
  endtask

  task automatic tDisabled();
    wr(8'h00, 32'h0000 | (3 << 8));
    startRun();
    chk("R4 disabled done", doneFlag, 1);
    repeat (3) @(negedge clk);
    chk("R4 disabled emits", capN, 0);
    chk("R4 disabled busy", busy, 0);
  endtask

  task automatic tNoRestart();
    wr(8'h00, 32'h8000 | (2 << 8));
    startRun();
    waitIdle();
    wr(8'h0C, 32'h1);
    capN = 0;
    wr(8'h04, 32'h8000);
    repeat (4) @(negedge clk);
    chk("R5 rewrite no emit", capN, 0);
    chk("R5 rewrite no done", doneFlag, 0);
  endtask

  task automatic tAbort();
    readyVal = 1'b0;
    wr(8'h00, 32'h8000 | (4 << 8));
    startRun();
    chk("R6 running before stop", busy, 1);
    wr(8'h04, 32'h0);
    chk("R6 valid after stop", outValid, 0);
    chk("R6 busy after stop", busy, 0);
    chk("R6 done after stop", doneFlag, 0);
    readyVal = 1'b1;
  endtask

  task automatic tClear();
    wr(8'h00, 32'h8000);
    startRun();
    chk("R9 done set", doneFlag, 1);
    wr(8'h0C, 32'h0);
    chk("R9 write zero keeps", doneFlag, 1);
    wr(8'h0C, 32'h1);
    chk("R9 write one clears", doneFlag, 0);
  endtask

  task automatic tIrq();
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h8000);
    startRun();
    chk("R10 masked irq", irq, 0);
    wr(8'h08, 32'h1);
    chk("R10 enabled irq", irq, 1);
    wr(8'h0C, 32'h1);
    chk("R10 irq after clear", irq, 0);
    wr(8'h08, 32'h0);
  endtask

  task automatic tLatch();
    readyVal = 1'b0;
    wr(8'h00, 32'h8000 | (3 << 8));
    startRun();
    wr(8'h00, 32'h8000 | (1 << 8));
    readyVal = 1'b1;
    waitIdle();
    cmpList("R11 count latched", 3);
  endtask

  task automatic tFull();
    for (int i = 0; i < 32; i++)
      putSlot(i, {8'h00, (i % 3 == 0) ? 8'h80 : 8'h00, 8'(i), 8'(255 - i)});
    wr(8'h00, 32'h8000 | (31 << 8));
    startRun();
    waitIdle();
    cmpList("R2 R3 full list", 31);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tStall();
    tZero();
    tDisabled();
    tNoRestart();
    tAbort();
    tClear();
    tIrq();
    tLatch();
    tFull();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule